// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key-Protected Control

This block is a watchdog timer with two modes. In plain timeout mode it raises a one-cycle reset pulse when software fails to clear it within a set number of watchdog clock ticks. In window mode the count is split into two phases. The first is a banned phase, in which a clear counts as a fault. The second is an open phase, in which a clear is accepted. The total timeout covers both phases, and a clear that comes too early fires the reset at once.

All configuration sits in one control word. A write to it is accepted only as the second of two back-to-back writes: the first carries an arming key and the second carries a commit key. This makes a stray store unlikely to change the watchdog. A lock flag, once committed, freezes the word until the block's own reset. The watchdog counts ticks from one of two slow clock inputs. Both inputs are oversampled in the system clock domain, and a gating flag can stop the count.

Top module: `wdt_window`

## Requirements
- R1: A control write (`addr_i`=0) changes the control word only when it carries 0xAA in `wdata_i[31:24]` and comes directly after a control write that carried 0x55 in the same field. The new field values come from the 0xAA write.
- R2: Any other write between the 0x55 and 0xAA steps aborts the sequence, and the sequence must then start again from 0x55. Such writes are a wrong key or a write to the clear address (`addr_i`=1). Bits 31:24 always read back as zero.
- R3: After `rst_ni`, the control word reads 0x00010080. Its fields are: ban select in bits 22:18, source select in bit 17, clock gate in bit 16, period select in bits 12:8, calibration-done in bit 7, lock in bit 4, window mode in bit 3, spare flag in bit 1 and enable in bit 0. All other bits read zero.
- R4: In plain mode (bit 3 = 0), with enable and the clock gate set, one pulse occurs once 2^(period+1) ticks have been counted since enabling or since the last restart.
- R5: In window mode (bit 3 = 1), the timeout is 2^(ban+1) + 2^(period+1) ticks.
- R6: In window mode, a clear while the count is below 2^(ban+1) produces a reset pulse and restarts the count. A clear at a count of 2^(ban+1) or more restarts the count with no pulse.
- R7: The count restarts on either of two events: `clr_i` high for one cycle, or a write to the clear address.
- R8: `wdt_rst_o` is high for one cycle per event, and the count restarts from zero after each pulse.
- R9: Once a committed word has the lock bit (bit 4) set, no later write changes the control word. Only `rst_ni` clears the lock.
- R10: A committed write leaves the window-mode bit unchanged while enable is currently 1. The other fields of that write still update.
- R11: Source select 0 counts rising edges of `rc_clk_i`, and 1 counts rising edges of `xtal_clk_i`. Clock gate 0 stops the count. With enable at 0 the count is held at zero, there are no pulses, and clears have no effect.
- R12: The calibration-done bit (bit 7) and the spare flag (bit 1) are stored only, and read back as last committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rc_clk_i | input | 1 | Slow clock source 0 (on-chip RC) |
| xtal_clk_i | input | 1 | Slow clock source 1 (32 kHz crystal) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control word, 1 clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Control word readback |
| clr_i | input | 1 | Clear strobe |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench uses the default parameters: 5-bit select fields, a 34-bit counter and a two-stage tick synchronizer. It programs period and ban values of 0 to 1, which gives windows of 2 to 8 ticks, so every expiry and window boundary can be reached in a few hundred system cycles. The two slow clocks run at 1/16 and 1/24 of the system clock and can be stopped one at a time. This makes the source select show itself as pulses that do or do not appear. Each clear is placed at an exact tick count, including the counts just below and at the end of the banned phase.

// File: rtl/wdt_window_pkg.sv
package wdt_window_pkg;
  localparam int FIELD_W = 5;
  localparam logic [7:0] KEY_ARM = 8'h55;
  localparam logic [7:0] KEY_GO  = 8'hAA;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;

  typedef struct packed {
    logic [FIELD_W-1:0] ban_sel;
    logic               src_sel;
    logic               clk_en;
    logic [FIELD_W-1:0] per_sel;
    logic               cal_done;
    logic               lock;
    logic               win_mode;
    logic               spare;
    logic               enable;
  } cfg_t;

  localparam cfg_t CFG_RST = '{ban_sel: '0, src_sel: 1'b0, clk_en: 1'b1, per_sel: '0,
                               cal_done: 1'b1, lock: 1'b0, win_mode: 1'b0,
                               spare: 1'b0, enable: 1'b0};

  function automatic logic [31:0] cfg_pack(cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[22:18] = c.ban_sel;
    w[17]    = c.src_sel;
    w[16]    = c.clk_en;
    w[12:8]  = c.per_sel;
    w[7]     = c.cal_done;
    w[4]     = c.lock;
    w[3]     = c.win_mode;
    w[1]     = c.spare;
    w[0]     = c.enable;
    return w;
  endfunction

  function automatic cfg_t cfg_unpack(logic [31:0] w);
    cfg_t c;
    c.ban_sel  = w[22:18];
    c.src_sel  = w[17];
    c.clk_en   = w[16];
    c.per_sel  = w[12:8];
    c.cal_done = w[7];
    c.lock     = w[4];
    c.win_mode = w[3];
    c.spare    = w[1];
    c.enable   = w[0];
    return c;
  endfunction
endpackage

// File: rtl/wdt_window_regs.sv
module wdt_window_regs
  import wdt_window_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output cfg_t        cfg_o
);
  key_state_e state_q, state_d;
  cfg_t       cfg_q, cfg_d;
  logic [7:0] key;

  assign key = wdata_i[31:24];

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    if (wr_en_i) begin
      state_d = KS_IDLE;  // any write ends an armed sequence
      if (!addr_i) begin
        if (state_q == KS_IDLE && key == KEY_ARM) begin
          state_d = KS_ARMED;
        end else if (state_q == KS_ARMED && key == KEY_GO && !cfg_q.lock) begin
          cfg_d = cfg_unpack(wdata_i);
          if (cfg_q.enable) cfg_d.win_mode = cfg_q.win_mode;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      cfg_q   <= CFG_RST;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  assert_commit_needs_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != $past(cfg_q)) |->
      $past(wr_en_i && !addr_i && state_q == KS_ARMED && wdata_i[31:24] == KEY_GO));

  assert_lock_freezes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.lock) |-> (cfg_q == $past(cfg_q)));

  assert_mode_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q.enable) |-> (cfg_q.win_mode == $past(cfg_q.win_mode)));
endmodule

// File: rtl/wdt_window_tick.sv
module wdt_window_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rc_clk_i,
  input  logic xtal_clk_i,
  input  logic src_sel_i,
  input  logic clk_en_i,
  output logic tick_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] rise;

  assign src_clk = {xtal_clk_i, rc_clk_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [SYNC_STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SYNC_STAGES-1:0], src_clk[g]};
    end
    assign rise[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  end

  assign tick_o = clk_en_i & rise[src_sel_i];
endmodule

// File: rtl/wdt_window_cnt.sv
module wdt_window_cnt
  import wdt_window_pkg::*;
#(
  parameter int CNT_W = (1 << FIELD_W) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               win_i,
  input  logic [FIELD_W-1:0] ban_sel_i,
  input  logic [FIELD_W-1:0] per_sel_i,
  input  logic               tick_i,
  input  logic               clr_i,
  output logic               wdt_rst_o
);
  localparam int SH_W = FIELD_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_len, ban_len, limit;
  logic [SH_W-1:0]  per_sh, ban_sh;
  logic             banned, bad_clr, expire, rst_q;

  assign per_sh  = SH_W'(per_sel_i) + SH_W'(1);
  assign ban_sh  = SH_W'(ban_sel_i) + SH_W'(1);
  assign per_len = CNT_W'(1) << per_sh;
  assign ban_len = win_i ? (CNT_W'(1) << ban_sh) : '0;
  assign limit   = ban_len + per_len;

  assign banned  = win_i && (cnt_q < ban_len);
  assign bad_clr = run_i && clr_i && banned;
  // >= covers a period shortened below the current count
  assign expire  = run_i && !clr_i && tick_i && (cnt_q >= limit - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || clr_i || expire) cnt_d = '0;
    else if (tick_i)               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= bad_clr | expire;
    end
  end

  assign wdt_rst_o = rst_q;

  assert_restart_after_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (cnt_q == '0));

  assert_late_clear_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !banned) |=> !wdt_rst_o);

  assert_idle_no_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!wdt_rst_o && cnt_q == '0));
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_window_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rc_clk_i,
  input  logic        xtal_clk_i,
  input  logic        wr_en_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        clr_i,
  output logic        wdt_rst_o
);
  localparam int CNT_W = (1 << FIELD_W) + 2;

  cfg_t cfg;
  logic tick, clr_any;

  assign clr_any = clr_i | (wr_en_i & addr_i);

  wdt_window_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg)
  );

  wdt_window_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rc_clk_i   (rc_clk_i),
    .xtal_clk_i (xtal_clk_i),
    .src_sel_i  (cfg.src_sel),
    .clk_en_i   (cfg.clk_en),
    .tick_o     (tick)
  );

  wdt_window_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cfg.enable),
    .win_i     (cfg.win_mode),
    .ban_sel_i (cfg.ban_sel),
    .per_sel_i (cfg.per_sel),
    .tick_i    (tick),
    .clr_i     (clr_any),
    .wdt_rst_o (wdt_rst_o)
  );

  assign rdata_o = cfg_pack(cfg);
endmodule

// File: tb/wdt_window_test.sv
module wdt_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rc_clk = 1'b0, xt_clk = 1'b0;
  logic        rc_run = 1'b1, xt_run = 1'b1;
  logic        wr_en = 1'b0, addr = 1'b0, clr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;
  int          n_checks = 0, n_fail = 0, pulses = 0;
  bit          done = 1'b0;

  wdt_window uut (
    .clk_i(clk), .rst_ni(rst_n), .rc_clk_i(rc_clk), .xtal_clk_i(xt_clk),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .clr_i(clr), .wdt_rst_o(wdt_rst)
  );

  always #10 clk = ~clk;  // 50 MHz

  initial begin
    #5;
    forever begin #160; if (rc_run) rc_clk = ~rc_clk; end
  end
  initial begin
    #5;
    forever begin #240; if (xt_run) xt_clk = ~xt_clk; end
  end

  always @(negedge clk) if (rst_n && wdt_rst === 1'b1) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [4:0] ban, input logic src, input logic cen,
                                     input logic [4:0] per, input logic cal, input logic lock,
                                     input logic mode, input logic spare, input logic en);
    return {8'h00, 1'b0, ban, src, cen, 3'b000, per, cal, 2'b00, lock, mode, 1'b0, spare, en};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic key_wr(input logic [31:0] w);
    bus_wr(1'b0, {8'h55, 24'h0});
    bus_wr(1'b0, {8'hAA, w[23:0]});
  endtask

  task automatic sync_src(input bit xt);
    if (xt) @(posedge xt_clk); else @(posedge rc_clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n, input bit xt);
    for (int i = 0; i < n; i++) sync_src(xt);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R3 reset value", rdata, 32'h0001_0080);
    check("R3 no pulse in reset state", {31'h0, wdt_rst}, 32'h0);
  endtask

  task automatic t_key();
    logic [31:0] w;
    do_reset();
    w = cw(5'd3, 1'b0, 1'b1, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    bus_wr(1'b0, {8'hAA, w[23:0]});
    check("R1 lone commit key ignored", rdata, 32'h0001_0080);
    bus_wr(1'b0, {8'h55, 24'h0});
    bus_wr(1'b0, {8'h33, w[23:0]});
    bus_wr(1'b0, {8'hAA, w[23:0]});
    check("R2 wrong key aborts, restart needed", rdata, 32'h0001_0080);
    bus_wr(1'b0, {8'h55, 24'h0});
    bus_wr(1'b1, 32'h0);
    bus_wr(1'b0, {8'hAA, w[23:0]});
    check("R2 clear write aborts sequence", rdata, 32'h0001_0080);
    key_wr(w);
    check("R1 valid sequence commits", rdata, w);
    check("R2 key field reads zero", {24'h0, rdata[31:24]}, 32'h0);
    w = cw(5'd3, 1'b0, 1'b1, 5'd9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    key_wr(w);
    check("R12 stored flags read back", rdata, w);
  endtask

  task automatic t_basic();
    int p0;
    do_reset();
    sync_src(1'b0);
    key_wr(cw(5'd0, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    p0 = pulses;
    wait_ticks(3, 1'b0);
    check("R4 no pulse before period", pulses, p0);
    wait_ticks(1, 1'b0);
    check("R4 pulse at 4 ticks", pulses, p0 + 1);
    wait_ticks(3, 1'b0);
    check("R8 single-cycle pulse, count restarted", pulses, p0 + 1);
    wait_ticks(1, 1'b0);
    check("R8 second expiry after restart", pulses, p0 + 2);
  endtask

  task automatic t_clear();
    int p0;
    do_reset();
    sync_src(1'b0);
    key_wr(cw(5'd0, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    p0 = pulses;
    wait_ticks(3, 1'b0);
    pulse_clr();
    wait_ticks(3, 1'b0);
    check("R7 strobe clear restarts count", pulses, p0);
    bus_wr(1'b1, 32'h0);
    wait_ticks(3, 1'b0);
    check("R7 bus clear restarts count", pulses, p0);
    wait_ticks(1, 1'b0);
    check("R7 expiry after bus clear", pulses, p0 + 1);
  endtask

  task automatic t_window();
    int p0;
    do_reset();
    sync_src(1'b0);
    key_wr(cw(5'd1, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1));
    check("R5 window mode committed", rdata[3], 1'b1);
    p0 = pulses;
    wait_ticks(7, 1'b0);
    check("R5 no pulse before ban+period", pulses, p0);
    wait_ticks(1, 1'b0);
    check("R5 pulse at 8 ticks", pulses, p0 + 1);
    wait_ticks(2, 1'b0);
    pulse_clr();
    check("R6 early clear fires reset", pulses, p0 + 2);
    wait_ticks(3, 1'b0);
    pulse_clr();
    check("R6 clear at last banned tick fires", pulses, p0 + 3);
    wait_ticks(4, 1'b0);
    pulse_clr();
    check("R6 clear at end of ban accepted", pulses, p0 + 3);
    wait_ticks(7, 1'b0);
    check("R6 accepted clear restarted count", pulses, p0 + 3);
    wait_ticks(1, 1'b0);
    check("R6 expiry after accepted clear", pulses, p0 + 4);
  endtask

  task automatic t_mode_lock();
    logic [31:0] l;
    do_reset();
    key_wr(cw(5'd0, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    key_wr(cw(5'd0, 1'b0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1));
    check("R10 mode held while enabled", rdata,
          cw(5'd0, 1'b0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    key_wr(cw(5'd0, 1'b0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    key_wr(cw(5'd0, 1'b0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    check("R10 mode written while disabled", rdata[3], 1'b1);
    l = cw(5'd2, 1'b0, 1'b1, 5'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    key_wr(l);
    check("R9 locking write commits", rdata, l);
    key_wr(cw(5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    check("R9 locked word unchanged", rdata, l);
    do_reset();
    check("R9 reset unlocks", rdata, 32'h0001_0080);
    key_wr(cw(5'd1, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R9 writes accepted after reset", rdata,
          cw(5'd1, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_source();
    int p0;
    do_reset();
    rc_run = 1'b0;
    sync_src(1'b1);
    key_wr(cw(5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    p0 = pulses;
    wait_ticks(2, 1'b1);
    check("R11 crystal source drives count", pulses, p0 + 1);
    rc_run = 1'b1;
    do_reset();
    xt_run = 1'b0;
    key_wr(cw(5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    p0 = pulses;
    wait_ticks(6, 1'b0);
    check("R11 unselected source ignored", pulses, p0);
    xt_run = 1'b1;
    do_reset();
    key_wr(cw(5'd0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    wait_ticks(6, 1'b0);
    check("R11 clock gate stops count", pulses, p0);
    do_reset();
    key_wr(cw(5'd1, 1'b0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    wait_ticks(6, 1'b0);
    pulse_clr();
    check("R11 disabled: no pulse, clear ignored", pulses, p0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_key();
    t_basic();
    t_clear();
    t_window();
    t_mode_lock();
    t_source();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule